// File: doc/BRIEF.md
# Serial Keyboard Scancode Filter and Command Responder

This block sits at the keyboard end of a serial keyboard channel. Raw make/break scancodes enter on one side. An extended-code prefix is consumed there, and Caps Lock and Num Lock events are filtered so that the host sees toggle behaviour. Each remaining code is translated through one of two small computed lookup tables, and the result goes into a byte queue.

On the host side, command bytes written to the channel are interpreted. Some of them replace the queue contents with a fixed reply. The host drains the queue one byte per read strobe. A level output stays high while any byte is waiting.

The translation tables are arithmetic stand-ins sized by parameters. The queue depth is a parameter.

Top module: `kbd_scan_responder`

## Requirements
- R1: After `rst_n` low or a cycle with `chan_clr` high, the queue is empty (`q_count`=0, `rx_avail`=0, `rd_data`=0x00). The prefix flag, the LED flag and both lock modes are back at zero.
- R2: A scancode whose bits 6:0 form index i is translated through the base table. The result is pushed with bit 7 of the raw code copied into bit 7. The base table entry is (5*i+3) mod 128 for 1 <= i < BASE_SPAN and 0 otherwise.
- R3: Code 0xE0 pushes nothing and sets a prefix flag. The next code that is not dropped is translated through the extended table, and the flag clears. The extended table entry is i XOR 0x55 for EXT_LO <= i < EXT_LO+EXT_SPAN and 0 otherwise.
- R4: A lock press (0x3A Caps, 0x45 Num) toggles bit 0 of that key's 2-bit mode. When the new mode equals 2, the event is dropped.
- R5: A lock release (0xBA Caps, 0xC5 Num) toggles bit 1 of that key's mode. When the new mode equals 3, the event is dropped.
- R6: Command 0x01 replaces the queue contents with 0xFF, 0x04, 0x7F, in that order.
- R7: Command 0x0E sets the LED flag. The next accepted command byte, of any value, is discarded and clears the flag.
- R8: Commands 0x07 and 0x0F replace the queue contents with 0xFE, 0x00.
- R9: A command byte is accepted only when `tx_en`=1 and `chan_off`=0. Any other accepted value changes nothing.
- R10: The queue is first-in first-out and holds QDEPTH bytes. A push while `q_count`=QDEPTH is discarded.
- R11: `rd_data` shows the oldest byte, or 0x00 when the queue is empty. `rd_pop` removes one byte. `rx_avail` stays high while bytes remain.
- R12: In a cycle where a command reply is loaded, the pop and any scancode push of that cycle are discarded. Lock-mode and prefix updates from the scancode still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_clr | input | 1 | Synchronous channel reset |
| scan_valid | input | 1 | Raw scancode strobe |
| scan_code | input | 8 | Raw scancode |
| cmd_valid | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Host command byte |
| tx_en | input | 1 | Channel transmit enable |
| chan_off | input | 1 | Channel disabled |
| rd_pop | input | 1 | Host read strobe, pops one byte |
| rd_data | output | 8 | Oldest queued byte or 0 |
| rx_avail | output | 1 | Queue not empty |
| q_count | output | $clog2(QDEPTH)+1 | Bytes in the queue |

## Verification
The bench builds the block with QDEPTH=8 and keeps the default table spans. A short queue lets random traffic fill it often, so discarded pushes at the full boundary are exercised many times. The defaults leave indices above 99 unmapped in the base table and leave the extended table sparse, so both the zero entries and the mapped entries of each table are reached.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  typedef enum logic [1:0] {RPL_NONE = 2'd0, RPL_RESET = 2'd1, RPL_LAYOUT = 2'd2} reply_e;

  localparam logic [7:0] SC_PREFIX  = 8'hE0;
  localparam logic [7:0] SC_CAPS_DN = 8'h3A;
  localparam logic [7:0] SC_NUM_DN  = 8'h45;
  localparam logic [7:0] SC_CAPS_UP = 8'hBA;
  localparam logic [7:0] SC_NUM_UP  = 8'hC5;
  localparam logic [7:0] HC_RESET   = 8'h01;
  localparam logic [7:0] HC_LED     = 8'h0E;
  localparam logic [7:0] HC_LAYOUT0 = 8'h07;
  localparam logic [7:0] HC_LAYOUT1 = 8'h0F;

  function automatic logic [6:0] base_lookup(input logic [6:0] idx, input int span);
    int v;
    if (idx == 7'd0 || int'(idx) >= span) return 7'd0;
    v = int'(idx) * 5 + 3;
    return v[6:0];
  endfunction

  function automatic logic [6:0] ext_lookup(input logic [6:0] idx, input int lo, input int span);
    if (int'(idx) < lo || int'(idx) >= lo + span) return 7'd0;
    return idx ^ 7'h55;
  endfunction

  function automatic int reply_len(input reply_e r);
    case (r)
      RPL_RESET:  return 3;
      RPL_LAYOUT: return 2;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [7:0] reply_byte(input reply_e r, input int k);
    if (r == RPL_RESET) begin
      case (k)
        0: return 8'hFF;
        1: return 8'h04;
        default: return 8'h7F;
      endcase
    end
    if (r == RPL_LAYOUT) return (k == 0) ? 8'hFE : 8'h00;
    return 8'h00;
  endfunction
endpackage

// File: rtl/kbd_xlate.sv
module kbd_xlate
  import kbd_pkg::*;
#(
  parameter int BASE_SPAN = 100,
  parameter int EXT_LO    = 28,
  parameter int EXT_SPAN  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       scan_valid,
  input  logic [7:0] scan_code,
  output logic       ev_push,
  output logic [7:0] ev_byte,
  output logic       ev_drop
);
  logic [1:0] caps_mode, num_mode, cur_mode, new_mode;
  logic       ext_pend;
  logic       is_caps, lock_dn, lock_up, is_prefix;
  logic [6:0] tbl;

  always_comb begin
    is_caps   = (scan_code == SC_CAPS_DN) || (scan_code == SC_CAPS_UP);
    lock_dn   = (scan_code == SC_CAPS_DN) || (scan_code == SC_NUM_DN);
    lock_up   = (scan_code == SC_CAPS_UP) || (scan_code == SC_NUM_UP);
    is_prefix = (scan_code == SC_PREFIX);
    cur_mode  = is_caps ? caps_mode : num_mode;
    new_mode  = cur_mode;
    if (lock_dn) new_mode = cur_mode ^ 2'b01;
    else if (lock_up) new_mode = cur_mode ^ 2'b10;
    ev_drop = scan_valid && ((lock_dn && new_mode == 2'd2) || (lock_up && new_mode == 2'd3));
    ev_push = scan_valid && !is_prefix && !ev_drop;
    tbl = ext_pend ? ext_lookup(scan_code[6:0], EXT_LO, EXT_SPAN)
                   : base_lookup(scan_code[6:0], BASE_SPAN);
    ev_byte = {scan_code[7], tbl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caps_mode <= 2'd0;
      num_mode  <= 2'd0;
      ext_pend  <= 1'b0;
    end else if (clr) begin
      caps_mode <= 2'd0;
      num_mode  <= 2'd0;
      ext_pend  <= 1'b0;
    end else if (scan_valid) begin
      if ((lock_dn || lock_up) && is_caps) caps_mode <= new_mode;
      if ((lock_dn || lock_up) && !is_caps) num_mode <= new_mode;
      if (is_prefix) ext_pend <= 1'b1;
      else if (!ev_drop) ext_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/kbd_cmd.sv
module kbd_cmd
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       tx_en,
  input  logic       chan_off,
  output reply_e     reply,
  output logic       led_skip
);
  logic led_flag, accept;

  always_comb begin
    accept   = cmd_valid && tx_en && !chan_off;
    led_skip = accept && led_flag;
    reply    = RPL_NONE;
    if (accept && !led_flag) begin
      case (cmd_byte)
        HC_RESET:               reply = RPL_RESET;
        HC_LAYOUT0, HC_LAYOUT1: reply = RPL_LAYOUT;
        default:                reply = RPL_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_flag <= 1'b0;
    else if (clr) led_flag <= 1'b0;
    else if (accept) led_flag <= led_flag ? 1'b0 : (cmd_byte == HC_LED);
  end
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo
  import kbd_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  reply_e        load,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] count,
  output logic          push_lost
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    push_ok   = push && (int'(count) != DEPTH);
    pop_ok    = pop && (count != '0);
    push_lost = push && !push_ok && (load == RPL_NONE) && !clr;
    head      = mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (load != RPL_NONE) begin
      rd_ptr <= '0;
      wr_ptr <= PW'(reply_len(load));
      count  <= CW'(reply_len(load));
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok) rd_ptr <= step(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && load != RPL_NONE) begin
      for (int k = 0; k < 3; k++) mem[k] <= reply_byte(load, k);
    end else if (!clr && push_ok) begin
      mem[wr_ptr] <= push_byte;
    end
  end
endmodule

// File: rtl/kbd_scan_responder.sv
module kbd_scan_responder
  import kbd_pkg::*;
#(
  parameter int QDEPTH    = 16,
  parameter int BASE_SPAN = 100,
  parameter int EXT_LO    = 28,
  parameter int EXT_SPAN  = 64,
  localparam int CW = $clog2(QDEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_clr,
  input  logic          scan_valid,
  input  logic [7:0]    scan_code,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  input  logic          tx_en,
  input  logic          chan_off,
  input  logic          rd_pop,
  output logic [7:0]    rd_data,
  output logic          rx_avail,
  output logic [CW-1:0] q_count
);
  logic       ev_push, ev_drop, led_skip, push_lost;
  logic [7:0] ev_byte, head;
  reply_e     reply;

  kbd_xlate #(.BASE_SPAN(BASE_SPAN), .EXT_LO(EXT_LO), .EXT_SPAN(EXT_SPAN)) u_xlate (
    .clk(clk), .rst_n(rst_n), .clr(chan_clr),
    .scan_valid(scan_valid), .scan_code(scan_code),
    .ev_push(ev_push), .ev_byte(ev_byte), .ev_drop(ev_drop)
  );

  kbd_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .clr(chan_clr),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .tx_en(tx_en), .chan_off(chan_off),
    .reply(reply), .led_skip(led_skip)
  );

  kbd_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(chan_clr), .load(reply),
    .push(ev_push), .push_byte(ev_byte), .pop(rd_pop),
    .head(head), .count(q_count), .push_lost(push_lost)
  );

  assign rx_avail = (q_count != '0);
  assign rd_data  = rx_avail ? head : 8'h00;
endmodule

// File: rtl/kbd_checker.sv
module kbd_checker #(
  parameter int QDEPTH = 16,
  localparam int CW = $clog2(QDEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_clr,
  input logic          scan_valid,
  input logic [7:0]    scan_code,
  input logic          tx_en,
  input logic          chan_off,
  input logic          rd_pop,
  input logic [7:0]    rd_data,
  input logic          rx_avail,
  input logic [CW-1:0] q_count,
  input logic          ev_push,
  input logic [1:0]    reply
);
  p_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(q_count) <= QDEPTH);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chan_clr |=> (q_count == '0 && !rx_avail && rd_data == 8'h00));

  p_empty_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_avail |-> rd_data == 8'h00);

  p_prefix_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_code == 8'hE0) |-> !ev_push);

  p_reset_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reply == 2'd1 && !chan_clr) |=> (int'(q_count) == 3 && rd_data == 8'hFF));

  p_layout_reply_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reply == 2'd2 && !chan_clr) |=> (int'(q_count) == 2 && rd_data == 8'hFE));

  p_full_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_clr && reply == 2'd0 && int'(q_count) == QDEPTH && !rd_pop) |=> int'(q_count) == QDEPTH);

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en || chan_off) |-> reply == 2'd0);
endmodule

bind kbd_scan_responder kbd_checker #(.QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_clr(chan_clr), .scan_valid(scan_valid),
  .scan_code(scan_code), .tx_en(tx_en), .chan_off(chan_off), .rd_pop(rd_pop),
  .rd_data(rd_data), .rx_avail(rx_avail), .q_count(q_count),
  .ev_push(ev_push), .reply(reply)
);

// File: tb/tb_kbd_scan_responder.sv
`timescale 1ns/1ps
module tb_kbd_scan_responder;
  localparam int D  = 8;
  localparam int CW = $clog2(D) + 1;

  logic clk = 0, rst_n = 0, chan_clr = 0, scan_valid = 0, cmd_valid = 0;
  logic tx_en = 0, chan_off = 0, rd_pop = 0;
  logic [7:0] scan_code = 0, cmd_byte = 0;
  logic [7:0] rd_data;
  logic rx_avail;
  logic [CW-1:0] q_count;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  logic [7:0] mq[$];
  int caps_m = 0, num_m = 0;
  bit ext_m = 0, led_m = 0;

  always #2 clk = ~clk;

  kbd_scan_responder #(.QDEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .chan_clr(chan_clr), .scan_valid(scan_valid),
    .scan_code(scan_code), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .tx_en(tx_en), .chan_off(chan_off), .rd_pop(rd_pop),
    .rd_data(rd_data), .rx_avail(rx_avail), .q_count(q_count)
  );

  function automatic logic [7:0] exp_xlate(input logic [7:0] c, input bit ext);
    int i = c & 8'h7F;
    int v = 0;
    if (ext) begin
      if (i >= 28 && i < 92) v = i ^ 'h55;
    end else if (i > 0 && i < 100) begin
      v = (i * 5 + 3) % 128;
    end
    return 8'(v) | (c & 8'h80);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    mq.delete(); caps_m = 0; num_m = 0; ext_m = 0; led_m = 0;
  endtask

  task automatic compare(input string tag);
    logic [7:0] e = (mq.size() != 0) ? mq[0] : 8'h00;
    chk(int'(q_count) == mq.size(), {tag, " count"}, q_count, mq.size());
    chk(rd_data == e, {tag, " data"}, rd_data, e);
    chk(rx_avail == (mq.size() != 0), {tag, " avail"}, rx_avail, mq.size() != 0);
  endtask

  task automatic step(input bit sv, input logic [7:0] sc, input bit cv, input logic [7:0] cb,
                      input bit te, input bit off, input bit pop, input bit clr, input string tag);
    int r = 0; bit push = 0; logic [7:0] pb = 0; int sz0;
    @(negedge clk);
    scan_valid = sv; scan_code = sc; cmd_valid = cv; cmd_byte = cb;
    tx_en = te; chan_off = off; rd_pop = pop; chan_clr = clr;
    @(posedge clk); #1;
    if (clr) model_clear();
    else begin
      if (cv && te && !off) begin
        if (led_m) led_m = 0;
        else if (cb == 8'h01) r = 1;
        else if (cb == 8'h0E) led_m = 1;
        else if (cb == 8'h07 || cb == 8'h0F) r = 2;
      end
      if (sv) begin
        bit drop = 0; int m;
        if (sc == 8'h3A || sc == 8'h45 || sc == 8'hBA || sc == 8'hC5) begin
          m = (sc == 8'h3A || sc == 8'hBA) ? caps_m : num_m;
          if (sc[7]) begin m = m ^ 2; drop = (m == 3); end
          else begin m = m ^ 1; drop = (m == 2); end
          if (sc == 8'h3A || sc == 8'hBA) caps_m = m; else num_m = m;
        end
        if (sc == 8'hE0) ext_m = 1;
        else if (!drop) begin
          push = 1; pb = exp_xlate(sc, ext_m); ext_m = 0;
        end
      end
      if (r == 1) mq = '{8'hFF, 8'h04, 8'h7F};
      else if (r == 2) mq = '{8'hFE, 8'h00};
      else begin
        sz0 = mq.size();
        if (pop && sz0 > 0) void'(mq.pop_front());
        if (push && sz0 < D) mq.push_back(pb);
      end
    end
    compare(tag);
  endtask

  task automatic scan(input logic [7:0] c, input string tag);
    step(1, c, 0, 0, 1, 0, 0, 0, tag);
  endtask
  task automatic cmd(input logic [7:0] c, input bit te, input bit off, input string tag);
    step(0, 0, 1, c, te, off, 0, 0, tag);
  endtask
  task automatic pop1(input string tag);
    step(0, 0, 0, 0, 1, 0, 1, 0, tag);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual=%0d expected<100000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    process::self().srandom(32'h5EED);
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk); rst_n = 1;
    scan(8'h10, "R2 make"); scan(8'h90, "R2 break"); scan(8'h70, "R2 unmapped");
    chk(rd_data == exp_xlate(8'h10, 0), "R2 head", rd_data, exp_xlate(8'h10, 0));
    pop1("R11 pop"); pop1("R11 pop"); pop1("R11 pop"); pop1("R11 empty pop");
    chk(rd_data == 8'h00, "R11 empty data", rd_data, 0);
    scan(8'hE0, "R3 prefix"); scan(8'hB0, "R3 ext release"); scan(8'h30, "R3 cleared");
    scan(8'hE0, "R3 prefix"); scan(8'h05, "R3 ext unmapped");
    step(0, 0, 0, 0, 1, 0, 0, 1, "R1 chan clear");
    scan(8'h3A, "R4 caps press"); scan(8'hBA, "R5 caps release drop");
    scan(8'h3A, "R4 caps press drop"); scan(8'hBA, "R5 caps release");
    scan(8'h45, "R4 num press"); scan(8'hE0, "R3 prefix"); scan(8'hC5, "R5 num drop keeps prefix");
    scan(8'h45, "R4 num drop"); scan(8'h20, "R3 ext after drops");
    cmd(8'h01, 1, 0, "R6 reset cmd");
    chk(rd_data == 8'hFF, "R6 first byte", rd_data, 8'hFF);
    pop1("R6 pop"); pop1("R6 pop");
    chk(rd_data == 8'h7F, "R6 last byte", rd_data, 8'h7F);
    cmd(8'h0E, 1, 0, "R7 led"); cmd(8'h01, 1, 0, "R7 swallowed"); cmd(8'h07, 1, 0, "R8 layout");
    cmd(8'h0F, 1, 0, "R8 layout alt");
    cmd(8'h01, 0, 0, "R9 tx off"); cmd(8'h01, 1, 1, "R9 disabled"); cmd(8'h22, 1, 0, "R9 other");
    for (int k = 0; k < D + 3; k++) scan(8'h11 + 8'(k), "R10 fill");
    chk(int'(q_count) == D, "R10 full", q_count, D);
    step(1, 8'h12, 0, 0, 1, 0, 1, 0, "R10 full push with pop");
    step(1, 8'h13, 1, 8'h0F, 1, 0, 1, 0, "R12 reply wins");
    step(1, 8'h3A, 1, 8'h01, 1, 0, 0, 0, "R12 lock update kept");
    scan(8'hBA, "R12 release after");
    step(0, 0, 0, 0, 1, 0, 0, 1, "R1 clear");
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 9);
      logic [7:0] c = 8'($urandom);
      if (sel == 0) c = 8'hE0;
      else if (sel == 1) c = 8'h3A;
      else if (sel == 2) c = 8'hBA;
      else if (sel == 3) c = 8'h45;
      else if (sel == 4) c = 8'hC5;
      step($urandom_range(0, 3) != 0, c, $urandom_range(0, 15) == 0,
           ($urandom_range(0, 1) != 0) ? 8'($urandom_range(0, 15)) : 8'($urandom),
           $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 200) == 0, "R10 R11 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule